// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel NOR flash. It drives the asynchronous address, data and strobe bus. A single request from the system starts one of three operations: program one byte, erase one sector, or erase the whole chip. The block sends the unlock and command writes that the operation needs. It then reads the status byte until it can reach a verdict. Two verdict methods are available: a toggle method that compares bit 6 across back-to-back reads, and a data-polling method that compares bit 7 with the expected value.

A verdict is reported as a one-clock pass or fail pulse. Before a fail is reported, the block writes the read-mode return command, so the flash is back in array-read mode when the host sees the failure. Every bus cycle has a setup phase, an active strobe phase and a hold phase, and each phase lasts a parameterized number of clocks. A watchdog limits the number of status reads an operation may spend without reaching a verdict.

Top module: `flash_poller`

## Requirements
- R1: With `reqMode` = 0 (program), the bus carries exactly four writes in this order: AAh@555h, 55h@2AAh, A0h@555h, then `reqData`@`reqAddr`.
- R2: With `reqMode` = 1 (sector erase), the bus carries six writes in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h@`reqAddr`.
- R3: With `reqMode` = 2 or 3 (chip erase), the six writes match R2, except that the last one is 10h@555h.
- R4: During a write strobe, `flCeN` = 0, `flWeN` = 0, `flOeN` = 1 and `flDqOe` = 1. During a read strobe, `flCeN` = 0, `flOeN` = 0, `flWeN` = 1 and `flDqOe` = 0. The two strobes are never active together.
- R5: Status reads go to `reqAddr`. The first one starts only after the last command write has ended.
- R6: With `reqMethod` = 0 (toggle), reads are taken in pairs. If bit 6 is equal in both reads of a pair, the verdict is pass.
- R7: In toggle mode, if bit 6 differs within a pair and bit 5 of the pair's second read is 0, the block takes another pair.
- R8: In toggle mode, if bit 6 differs and bit 5 of the second read is 1, the block takes one confirmation pair. An equal bit 6 in that pair means pass; a different bit 6 means fail.
- R9: With `reqMethod` = 1 (data polling), each read compares bit 7 with the expected value. The expected value is `reqData[7]` for a program and 1 for either erase. A match means pass. A mismatch with bit 5 = 0 leads to another read.
- R10: In data polling, a mismatch with bit 5 = 1 leads to exactly one more read. That read passes only if its bit 7 matches.
- R11: On fail, the block writes F0h@000h before it raises `doneFail`.
- R12: The watchdog works as follows. If, after `MAX_POLLS` status reads, the method would still ask for another ordinary read, the verdict is fail.
- R13: `busy` rises in the cycle after a start request is accepted while idle. `busy` stays high until the verdict. `donePass` or `doneFail` is high for exactly one clock, in the first cycle with `busy` low. A start request made while busy is ignored. While the block is idle, all strobes are high.
- R14: Each strobe stays low for exactly `PULSE_CYC` clocks. Between two strobes there are at least `SETUP_CYC`+`HOLD_CYC` clocks with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Start request, sampled while idle |
| reqMode | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| reqMethod | input | 1 | 0 toggle compare, 1 data polling |
| reqAddr | input | ADDR_W | Target byte or sector address |
| reqData | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| donePass | output | 1 | One-clock pass pulse |
| doneFail | output | 1 | One-clock fail pulse |
| flAddr | output | ADDR_W | Flash address bus |
| flDqOut | output | 8 | Data toward the flash |
| flDqOe | output | 1 | Drive enable for `flDqOut` |
| flDqIn | input | 8 | Data from the flash |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |

## Verification
`busy` is due one clock after the start request is sampled. Each bus cycle then takes one issue clock plus `SETUP_CYC`+`PULSE_CYC`+`HOLD_CYC` clocks. The verdict pulse lands in the clock right after the hold phase of the last read, or of the reset write when the verdict is fail.

The bench drives inputs and samples outputs on falling clock edges. It records every strobe as it ends and measures each strobe's width in sampled clocks. It compares the recorded transaction list and the verdict with lists built by a behavioural model of the command sequences and the two polling methods. The bench checks `busy` one falling edge after the start pulse, and checks that the done pulse is gone one falling edge after it first appears.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  localparam logic [1:0] MODE_PROG = 2'd0;
  localparam logic [1:0] MODE_SECT = 2'd1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_HOLD} busPhase_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_CMDW, S_RD, S_RDW, S_RST, S_RSTW
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       go;
    logic       isWrite;
    logic       isReset;
    logic [2:0] step;
    logic       latchReq;
  } busCmd_t;
endpackage

// File: rtl/fpoll_datapath.sv
module fpoll_datapath
  import fpoll_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        flDqIn,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              busDone,
  output logic [7:0]        rdByte,
  output logic              lastStep,
  output logic              expBit7
);
  localparam int MAX_C = (SETUP_CYC > PULSE_CYC)
                       ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                       : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'(12'h2AA);

  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;
  logic [1:0]        tgtMode;
  logic              isProg, isChip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
      tgtMode <= '0;
    end else if (cmd.latchReq) begin
      tgtAddr <= reqAddr;
      tgtData <= reqData;
      tgtMode <= reqMode;
    end
  end

  assign isProg   = (tgtMode == MODE_PROG);
  assign isChip   = tgtMode[1];
  assign lastStep = (cmd.step == (isProg ? 3'd3 : 3'd5));
  assign expBit7  = isProg ? tgtData[7] : 1'b1;

  // command table, indexed by step
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;
  always_comb begin
    case (cmd.step)
      3'd0: begin cmdAddr = UNLOCK_A; cmdData = 8'hAA; end
      3'd1: begin cmdAddr = UNLOCK_B; cmdData = 8'h55; end
      3'd2: begin cmdAddr = UNLOCK_A; cmdData = isProg ? 8'hA0 : 8'h80; end
      3'd3: begin
        cmdAddr = isProg ? tgtAddr : UNLOCK_A;
        cmdData = isProg ? tgtData : 8'hAA;
      end
      3'd4: begin cmdAddr = UNLOCK_B; cmdData = 8'h55; end
      default: begin
        cmdAddr = isChip ? UNLOCK_A : tgtAddr;
        cmdData = isChip ? 8'h10 : 8'h30;
      end
    endcase
  end

  logic [ADDR_W-1:0] selAddr;
  logic [7:0]        selData;
  always_comb begin
    if (cmd.isReset) begin
      selAddr = '0;
      selData = 8'hF0;
    end else if (cmd.isWrite) begin
      selAddr = cmdAddr;
      selData = cmdData;
    end else begin
      selAddr = tgtAddr;
      selData = '0;
    end
  end

  // strobe generator
  busPhase_t         phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        busData;
  logic              busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      busAddr <= '0;
      busData <= '0;
      busWr   <= 1'b0;
      rdByte  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (cmd.go) begin
          busAddr <= selAddr;
          busData <= selData;
          busWr   <= cmd.isWrite;
          phase   <= PH_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_ACT;
          cnt   <= CNT_W'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (cnt == '0) begin
          if (!busWr) rdByte <= flDqIn;
          phase <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign flAddr  = busAddr;
  assign flDqOut = busData;
  assign flDqOe  = busWr && (phase != PH_IDLE);
  assign flCeN   = (phase != PH_ACT);
  assign flWeN   = !((phase == PH_ACT) && busWr);
  assign flOeN   = !((phase == PH_ACT) && !busWr);
  assign busDone = (phase == PH_HOLD) && (cnt == '0);
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
#(
  parameter int MAX_POLLS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       reqMethod,
  input  logic       busDone,
  input  logic [7:0] rdByte,
  input  logic       lastStep,
  input  logic       expBit7,
  output busCmd_t    cmd,
  output logic       busy,
  output logic       donePass,
  output logic       doneFail
);
  localparam int PC_W = $clog2(MAX_POLLS + 4);

  ctrlState_t      state;
  logic [2:0]      step;
  logic [PC_W-1:0] pollCnt;
  logic            methodData, pairSecond, confirm, firstBit6;
  logic [PC_W-1:0] cntNext;
  logic            wdExpired;

  assign cntNext   = pollCnt + 1'b1;
  assign wdExpired = (cntNext >= PC_W'(MAX_POLLS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      step       <= '0;
      pollCnt    <= '0;
      methodData <= 1'b0;
      pairSecond <= 1'b0;
      confirm    <= 1'b0;
      firstBit6  <= 1'b0;
      donePass   <= 1'b0;
      doneFail   <= 1'b0;
    end else begin
      donePass <= 1'b0;
      doneFail <= 1'b0;
      case (state)
        S_IDLE: if (reqStart) begin
          state      <= S_CMD;
          step       <= '0;
          pollCnt    <= '0;
          pairSecond <= 1'b0;
          confirm    <= 1'b0;
          methodData <= reqMethod;
        end
        S_CMD:  state <= S_CMDW;
        S_CMDW: if (busDone) begin
          if (lastStep) state <= S_RD;
          else begin
            step  <= step + 1'b1;
            state <= S_CMD;
          end
        end
        S_RD:   state <= S_RDW;
        S_RDW: if (busDone) begin
          pollCnt <= cntNext;
          if (!methodData && !pairSecond) begin
            firstBit6  <= rdByte[6];
            pairSecond <= 1'b1;
            state      <= S_RD;
          end else begin
            pairSecond <= 1'b0;
            if (methodData ? (rdByte[7] == expBit7)
                           : (rdByte[6] == firstBit6)) begin
              state    <= S_IDLE;
              donePass <= 1'b1;
            end else if (confirm) begin
              state <= S_RST;
            end else if (rdByte[5]) begin
              confirm <= 1'b1;
              state   <= S_RD;
            end else if (wdExpired) begin
              state <= S_RST;
            end else begin
              state <= S_RD;
            end
          end
        end
        S_RST:  state <= S_RSTW;
        S_RSTW: if (busDone) begin
          state    <= S_IDLE;
          doneFail <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.go       = (state == S_CMD) || (state == S_RD) || (state == S_RST);
    cmd.isWrite  = (state == S_CMD) || (state == S_RST);
    cmd.isReset  = (state == S_RST);
    cmd.step     = step;
    cmd.latchReq = (state == S_IDLE) && reqStart;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/flash_poller.sv
module flash_poller
  import fpoll_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int MAX_POLLS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [1:0]        reqMode,
  input  logic              reqMethod,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              busy,
  output logic              donePass,
  output logic              doneFail,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  input  logic [7:0]        flDqIn,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);
  busCmd_t    cmd;
  logic       busDone, lastStep, expBit7;
  logic [7:0] rdByte;

  fpoll_ctrl #(.MAX_POLLS(MAX_POLLS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqMethod(reqMethod),
    .busDone(busDone), .rdByte(rdByte), .lastStep(lastStep),
    .expBit7(expBit7), .cmd(cmd), .busy(busy),
    .donePass(donePass), .doneFail(doneFail)
  );

  fpoll_datapath #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqMode(reqMode),
    .reqAddr(reqAddr), .reqData(reqData), .flDqIn(flDqIn),
    .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN),
    .busDone(busDone), .rdByte(rdByte), .lastStep(lastStep),
    .expBit7(expBit7)
  );
endmodule

// File: rtl/flash_poller_chk.sv
module flash_poller_chk (
  input logic clk,
  input logic rstN,
  input logic reqStart,
  input logic busy,
  input logic donePass,
  input logic doneFail,
  input logic flDqOe,
  input logic flCeN,
  input logic flOeN,
  input logic flWeN
);
  logic       prevWeN;
  logic [2:0] wrSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWeN <= 1'b1;
      wrSeen  <= '0;
    end else begin
      prevWeN <= flWeN;
      if (reqStart && !busy) wrSeen <= '0;
      else if (!prevWeN && flWeN && wrSeen != 3'd7) wrSeen <= wrSeen + 1'b1;
    end
  end

  assert_write_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (flOeN && !flCeN && flDqOe));
  assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flOeN |-> (flWeN && !flCeN && !flDqOe));
  assert_poll_after_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flOeN) |-> (wrSeen >= 3'd4));
  assert_busy_rise_R13: assert property (@(posedge clk) disable iff (!rstN)
    (reqStart && !busy) |=> busy);
  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    (donePass || doneFail) |-> (!busy && !(donePass && doneFail)));
  assert_pass_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    donePass |=> !donePass);
  assert_fail_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    doneFail |=> !doneFail);
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (flCeN && flWeN && flOeN));
endmodule

bind flash_poller flash_poller_chk chk_i (
  .clk(clk), .rstN(rstN), .reqStart(reqStart), .busy(busy),
  .donePass(donePass), .doneFail(doneFail), .flDqOe(flDqOe),
  .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
);

// File: tb/flash_poller_tb_top.sv
`timescale 1ns/1ps
module flash_poller_tb_top;
  localparam int AW = 17, SU = 1, PW = 2, HD = 1, MP = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqStart = 1'b0, reqMethod = 1'b0;
  logic [1:0]    reqMode = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          busy, donePass, doneFail, flDqOe, flCeN, flOeN, flWeN;
  logic [AW-1:0] flAddr;
  logic [7:0]    flDqOut, flDqIn;

  always #4 clk = ~clk;

  flash_poller #(.ADDR_W(AW), .SETUP_CYC(SU), .PULSE_CYC(PW),
                 .HOLD_CYC(HD), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqMode(reqMode),
    .reqMethod(reqMethod), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .donePass(donePass), .doneFail(doneFail),
    .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe), .flDqIn(flDqIn),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  // flash status model: one scripted byte per read strobe
  logic [7:0] script [0:63];
  int rIdx = 0;
  always_comb flDqIn = script[rIdx & 63];

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;
  // observed and expected transactions
  int tA [0:63]; int tD [0:63]; bit tW [0:63]; int tN = 0;
  int eA [0:63]; int eD [0:63]; bit eW [0:63]; int eN = 0;
  bit prevWe = 1, prevOe = 1, seenStrobe = 0;
  int weLow = 0, oeLow = 0, idleRun = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic monitor();
    if (!flWeN) chk("R4", "write strobe levels",
                    {flOeN, flCeN, flDqOe}, 3'b101);
    if (!flOeN) chk("R4", "read strobe levels",
                    {flWeN, flCeN, flDqOe}, 3'b100);
    if ((prevWe && !flWeN) || (prevOe && !flOeN)) begin
      if (seenStrobe) chk("R14", "gap between strobes",
                          int'(idleRun >= SU + HD), 1);
      seenStrobe = 1;
    end
    if (!prevWe && flWeN) begin
      chk("R14", "write pulse width", weLow, PW);
      tA[tN & 63] = int'(flAddr); tD[tN & 63] = int'(flDqOut);
      tW[tN & 63] = 1; tN++;
    end
    if (!prevOe && flOeN) begin
      chk("R14", "read pulse width", oeLow, PW);
      tA[tN & 63] = int'(flAddr); tD[tN & 63] = 0; tW[tN & 63] = 0; tN++;
      rIdx++;
    end
    weLow   = flWeN ? 0 : weLow + 1;
    oeLow   = flOeN ? 0 : oeLow + 1;
    idleRun = (flWeN && flOeN) ? idleRun + 1 : 0;
    prevWe  = flWeN;
    prevOe  = flOeN;
  endtask

  task automatic tick();
    @(negedge clk);
    monitor();
  endtask

  function automatic void addExp(int a, int d, bit w);
    eA[eN] = a; eD[eN] = d; eW[eN] = w; eN++;
  endfunction

  // behavioural reference of command list, polling and verdict
  function automatic bit model(int mode, bit method, int addr, int data);
    int rc = 0;
    bit conf = 0, pass = 0, e7;
    logic [7:0] a, b;
    eN = 0;
    addExp('h555, 'hAA, 1); addExp('h2AA, 'h55, 1);
    if (mode == 0) begin
      addExp('h555, 'hA0, 1); addExp(addr, data, 1);
    end else begin
      addExp('h555, 'h80, 1); addExp('h555, 'hAA, 1); addExp('h2AA, 'h55, 1);
      if (mode >= 2) addExp('h555, 'h10, 1); else addExp(addr, 'h30, 1);
    end
    e7 = (mode == 0) ? data[7] : 1'b1;
    forever begin
      if (!method) begin
        a = script[rc]; b = script[rc + 1]; rc += 2;
        if (a[6] == b[6]) begin pass = 1; break; end
      end else begin
        b = script[rc]; rc += 1;
        if (b[7] == e7) begin pass = 1; break; end
      end
      if (conf) break;
      if (b[5]) conf = 1;
      else if (rc >= MP) break;
    end
    for (int i = 0; i < rc; i++) addExp(addr, 0, 0);
    if (!pass) addExp(0, 'hF0, 1);
    return pass;
  endfunction

  task automatic runOp(string tag, int mode, bit method, int addr, int data,
                       bit inject);
    bit expPass;
    int waitCnt = 0;
    expPass = model(mode, method, addr, data);
    tN = 0; rIdx = 0; seenStrobe = 0;
    reqMode = 2'(mode); reqMethod = method;
    reqAddr = AW'(addr); reqData = 8'(data); reqStart = 1;
    tick();
    reqStart = 0;
    chk("R13", "busy after start", int'(busy), 1);
    while (!(donePass || doneFail) && waitCnt < 5000) begin
      if (inject && waitCnt == 6) begin
        reqStart = 1; reqMode = 2'd2; reqAddr = '0; reqMethod = ~method;
      end else reqStart = 0;
      tick();
      waitCnt++;
    end
    reqStart = 0;
    chk("R13", "busy low at verdict", int'(busy), 0);
    chk(tag, "verdict pass", int'(donePass), int'(expPass));
    chk(tag, "verdict fail", int'(doneFail), int'(!expPass));
    tick();
    chk("R13", "single-clock done pulse", int'(donePass || doneFail), 0);
    chk(tag, "transaction count", tN, eN);
    for (int i = 0; i < eN && i < tN; i++) begin
      chk(eW[i] ? (i < 6 ? tag : "R11") : "R5", "transaction kind",
          int'(tW[i]), int'(eW[i]));
      chk(eW[i] ? (i < 6 ? tag : "R11") : "R5", "transaction address",
          tA[i], eA[i]);
      if (eW[i]) chk(i < 6 ? tag : "R11", "write data", tD[i], eD[i]);
    end
    repeat (3) tick();
  endtask

  task automatic fillScript(int n, logic [7:0] v0, logic [7:0] v1);
    for (int i = 0; i < 64; i++) script[i] = (i % 2 == 0) ? v0 : v1;
    n = n;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      $display("FAIL watchdog: run did not end, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nChecks + 1, nErr + 1);
      $finish;
    end
  end

  initial begin
    fillScript(0, 8'h00, 8'h00);
    repeat (3) tick();
    rstN = 1;
    tick();
    chk("R13", "reset busy", int'(busy), 0);
    chk("R13", "reset strobes", {flCeN, flOeN, flWeN}, 3'b111);
    chk("R13", "reset done", int'(donePass || doneFail), 0);

    // R1 + R6/R7: program, toggle, one differing pair then a steady pair
    fillScript(0, 8'h12, 8'h12);
    script[0] = 8'h40; script[1] = 8'h00;
    runOp("R1", 0, 0, 'h01234, 'h5A, 0);
    // R7 explicit tag: two differing pairs before steady
    script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h00; script[3] = 8'h40;
    runOp("R7", 0, 0, 'h00F00, 'hC3, 0);
    // R2 + R8: sector erase, confirmation pair passes
    fillScript(0, 8'h44, 8'h44);
    script[0] = 8'h40; script[1] = 8'h20;
    runOp("R2", 1, 0, 'h1A000, 0, 0);
    // R3 + R8: chip erase, confirmation pair differs -> fail, reset write
    fillScript(0, 8'h40, 8'h00);
    script[1] = 8'h20;
    runOp("R8", 2, 0, 'h00000, 0, 0);
    // R9: program data polling, matches on third read
    fillScript(0, 8'h00, 8'h00);
    script[2] = 8'h80;
    runOp("R9", 0, 1, 'h00555, 'h80, 0);
    // R10: sector erase data poll, timeout bit then match
    fillScript(0, 8'h80, 8'h80);
    script[0] = 8'h20;
    runOp("R10", 1, 1, 'h03000, 0, 0);
    // R10/R11: program data poll mismatch twice -> fail
    fillScript(0, 8'hA0, 8'hA0);
    runOp("R11", 0, 1, 'h00777, 'h3C, 0);
    // R12: toggle never settles, watchdog
    fillScript(0, 8'h40, 8'h00);
    runOp("R12", 3, 0, 'h10000, 0, 0);
    // R12: data polling never matches
    fillScript(0, 8'h00, 8'h00);
    runOp("R12", 2, 1, 'h00000, 0, 0);
    // R13: start while busy is ignored
    fillScript(0, 8'h40, 8'h40);
    script[0] = 8'h00; script[1] = 8'h40;
    runOp("R13", 0, 0, 'h04444, 'h99, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule